// File: doc/BRIEF.md
# Inbound Requester to Partition Mapper

This block sits on the inbound path of a PCIe host bridge. Every inbound transaction carries a 16-bit requester ID (bus/device/function). The block looks that ID up in an internal requester table and tags the transaction with the isolation partition it belongs to. All three traffic classes go through the same lookup: memory reads and writes headed for DMA, memory writes that land in an MSI window, and error messages.

DMA results also carry a window select taken from address bit 59. This bit picks one of two translation windows in the partition's address space. A memory write whose address matches one of two programmable MSI windows becomes an MSI. It gets an interrupt index in the range 0 to 2047, taken from its data and address. The interrupt is authorized only when the partition stored in the interrupt descriptor table for that index equals the requester's partition. The first rejected interrupt latches a sticky flag together with the requester ID.

Both tables are synchronous RAMs that software fills through write ports. The lookup pipeline accepts one transaction per cycle. It uses a valid/ready handshake on both sides and has a fixed latency of two cycles.

Top module: `rid_partition_mapper`

## Requirements
- R1: After reset, `out_valid`, `err_flag` and `err_rid` are zero and `in_ready` is one.
- R2: The partition in `out_pe` is the requester-table entry addressed by the low `TBL_AW` bits of the requester ID, for every class. Upper ID bits play no part in the lookup. A table write is seen by transactions accepted in later cycles.
- R3: Kind codes 0 and 3 (read) always give class DMA (code 0). `out_dma_win` equals address bit 59 for DMA results and is 0 for every other class.
- R4: A transaction of kind 1 (memory write) is an MSI (class code 1) when `((addr ^ base) & ~mask) == 0` holds for window 0 or for window 1. Otherwise it is DMA. A read inside a window stays DMA.
- R5: The MSI interrupt index is `(msi_data[10:0] + addr[14:4]) mod 2048`. `out_irq` is 0 for non-MSI results.
- R6: For an MSI, `out_irq_fire` is 1 when the descriptor table entry at the index equals the requester's partition. Otherwise `out_irq_reject` is 1. The two flags are never set together.
- R7: Kind 2 (error message) gives class code 2 with the looked-up partition. Window select, index, fire and reject are all 0.
- R8: A transaction accepted in cycle c appears on the outputs in cycle c+2. Back-to-back inputs give one result per cycle.
- R9: While `out_valid` is high and `out_ready` is low, the outputs hold steady and `in_ready` is low.
- R10: The first rejected MSI after reset sets `err_flag` and records its full requester ID in `err_rid`. Both hold until reset, and later rejections do not change them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Requester table write enable |
| tbl_waddr | input | TBL_AW | Requester table write index |
| tbl_wdata | input | PE_W | Partition to store |
| ivt_we | input | 1 | Interrupt descriptor write enable |
| ivt_waddr | input | IRQ_W | Interrupt index to write |
| ivt_wdata | input | PE_W | Owning partition of that interrupt |
| msi_w0_base | input | 64 | MSI window 0 base |
| msi_w0_mask | input | 64 | MSI window 0 size minus one |
| msi_w1_base | input | 64 | MSI window 1 base |
| msi_w1_mask | input | 64 | MSI window 1 size minus one |
| in_valid | input | 1 | Transaction present |
| in_ready | output | 1 | Transaction accepted this cycle |
| in_kind | input | 2 | 0/3 read, 1 memory write, 2 error message |
| in_rid | input | RID_W | Requester ID |
| in_addr | input | 64 | Transaction address |
| in_msi_data | input | IRQ_W | Low bits of the write data |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result taken |
| out_class | output | 2 | 0 DMA, 1 MSI, 2 error |
| out_pe | output | PE_W | Partition of the requester |
| out_rid | output | RID_W | Requester ID of the result |
| out_dma_win | output | 1 | DMA window select |
| out_irq | output | IRQ_W | Interrupt index |
| out_irq_fire | output | 1 | MSI authorized |
| out_irq_reject | output | 1 | MSI refused |
| err_flag | output | 1 | Sticky rejection flag |
| err_rid | output | RID_W | Requester of first rejection |

## Verification
The bench targets the following corner cases:
- The index wrapping past 2047 from both the data and the address side. A design that drops the modulo or uses the wrong address bits would fire the wrong interrupt.
- Addresses one step below and above each MSI window, and reads that land inside a window. Off-by-one mask logic would turn these into MSIs.
- A requester ID with upper bits set, which catches lookups that index on the wrong bits.
- Back-pressure bursts, which expose results that change or get lost while stalled.
- Several rejections in a row, followed by a reset and a fresh rejection. A flag that records the latest requester instead of the first, or never clears, would show here.

// File: rtl/rpm_pkg.sv
package rpm_pkg;
  localparam int ADDR_W = 64;

  typedef enum logic [1:0] {
    KIND_RD     = 2'd0,
    KIND_WR     = 2'd1,
    KIND_ERRMSG = 2'd2,
    KIND_RD_ALT = 2'd3
  } rpm_kind_e;

  typedef enum logic [1:0] {
    CLS_DMA = 2'd0,
    CLS_MSI = 2'd1,
    CLS_ERR = 2'd2
  } rpm_class_e;

  // Address falls in a naturally aligned window given by base and size-1 mask.
  function automatic logic win_hit(input logic [ADDR_W-1:0] a,
                                   input logic [ADDR_W-1:0] base,
                                   input logic [ADDR_W-1:0] mask);
    return ((a ^ base) & ~mask) == '0;
  endfunction
endpackage

// File: rtl/rpm_sram.sv
module rpm_sram #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  // Read returns the old word on a same-address collision; data holds while re is low.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rpm_classify.sv
module rpm_classify
  import rpm_pkg::*;
#(
  parameter int IRQ_W   = 11,
  parameter int IDX_LSB = 4,
  parameter int WIN_BIT = 59
) (
  input  logic [1:0]        kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic [IRQ_W-1:0]  msi_data,
  input  logic [ADDR_W-1:0] w0_base,
  input  logic [ADDR_W-1:0] w0_mask,
  input  logic [ADDR_W-1:0] w1_base,
  input  logic [ADDR_W-1:0] w1_mask,
  output logic              hit0,
  output logic              hit1,
  output rpm_class_e        cls,
  output logic              dma_win,
  output logic [IRQ_W-1:0]  irq
);
  // Index arithmetic: data low bits plus an address-derived base, wrapping at 2**IRQ_W.
  function automatic logic [IRQ_W-1:0] irq_of(input logic [ADDR_W-1:0] a,
                                              input logic [IRQ_W-1:0]  d);
    logic [IRQ_W-1:0] s;
    s = d + a[IDX_LSB +: IRQ_W];
    return s;
  endfunction

  always_comb begin
    hit0    = win_hit(addr, w0_base, w0_mask);
    hit1    = win_hit(addr, w1_base, w1_mask);
    cls     = CLS_DMA;
    dma_win = 1'b0;
    irq     = '0;
    case (kind)
      KIND_ERRMSG: cls = CLS_ERR;
      KIND_WR: begin
        if (hit0 || hit1) begin
          cls = CLS_MSI;
          irq = irq_of(addr, msi_data);
        end else begin
          dma_win = addr[WIN_BIT];
        end
      end
      default: dma_win = addr[WIN_BIT];
    endcase
  end
endmodule

// File: rtl/rpm_authorize.sv
module rpm_authorize
  import rpm_pkg::*;
#(
  parameter int PE_W  = 8,
  parameter int RID_W = 16,
  parameter int IRQ_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  input  logic             out_ready,
  input  logic             a_valid,
  input  rpm_class_e       a_cls,
  input  logic [PE_W-1:0]  a_pe,
  input  logic [PE_W-1:0]  a_ivt_pe,
  input  logic [RID_W-1:0] a_rid,
  input  logic             a_win,
  input  logic [IRQ_W-1:0] a_irq,
  output logic             b_valid,
  output rpm_class_e       b_cls,
  output logic [PE_W-1:0]  b_pe,
  output logic [RID_W-1:0] b_rid,
  output logic             b_win,
  output logic [IRQ_W-1:0] b_irq,
  output logic             b_fire,
  output logic             b_reject,
  output logic             err_flag,
  output logic [RID_W-1:0] err_rid
);
  logic owner_match;
  logic is_msi;
  logic reject_evt;

  assign owner_match = (a_ivt_pe == a_pe);
  assign is_msi      = a_valid && (a_cls == CLS_MSI);
  assign reject_evt  = advance && is_msi && !owner_match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b_valid  <= 1'b0;
      b_cls    <= CLS_DMA;
      b_pe     <= '0;
      b_rid    <= '0;
      b_win    <= 1'b0;
      b_irq    <= '0;
      b_fire   <= 1'b0;
      b_reject <= 1'b0;
    end else if (advance) begin
      b_valid  <= a_valid;
      b_cls    <= a_cls;
      b_pe     <= a_pe;
      b_rid    <= a_rid;
      b_win    <= a_win;
      b_irq    <= a_irq;
      b_fire   <= is_msi && owner_match;
      b_reject <= is_msi && !owner_match;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_flag <= 1'b0;
      err_rid  <= '0;
    end else if (reject_evt && !err_flag) begin
      err_flag <= 1'b1;
      err_rid  <= a_rid;
    end
  end

  p_fire_reject_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    b_valid |-> !(b_fire && b_reject));

  p_auth_flags_only_msi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (b_valid && b_cls != CLS_MSI) |-> (!b_fire && !b_reject));

  p_sticky_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> (err_flag && $stable(err_rid)));

  p_stall_holds_output_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (b_valid && !out_ready) |=> (b_valid && $stable(b_pe) && $stable(b_cls)
                                 && $stable(b_irq) && $stable(b_fire)));
endmodule

// File: rtl/rid_partition_mapper.sv
module rid_partition_mapper
  import rpm_pkg::*;
#(
  parameter int PE_W    = 8,
  parameter int RID_W   = 16,
  parameter int TBL_AW  = 8,
  parameter int IRQ_W   = 11,
  parameter int IDX_LSB = 4,
  parameter int WIN_BIT = 59
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbl_we,
  input  logic [TBL_AW-1:0] tbl_waddr,
  input  logic [PE_W-1:0]   tbl_wdata,
  input  logic              ivt_we,
  input  logic [IRQ_W-1:0]  ivt_waddr,
  input  logic [PE_W-1:0]   ivt_wdata,
  input  logic [ADDR_W-1:0] msi_w0_base,
  input  logic [ADDR_W-1:0] msi_w0_mask,
  input  logic [ADDR_W-1:0] msi_w1_base,
  input  logic [ADDR_W-1:0] msi_w1_mask,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_kind,
  input  logic [RID_W-1:0]  in_rid,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [IRQ_W-1:0]  in_msi_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_class,
  output logic [PE_W-1:0]   out_pe,
  output logic [RID_W-1:0]  out_rid,
  output logic              out_dma_win,
  output logic [IRQ_W-1:0]  out_irq,
  output logic              out_irq_fire,
  output logic              out_irq_reject,
  output logic              err_flag,
  output logic [RID_W-1:0]  err_rid
);
  localparam int TBL_DEPTH = 1 << TBL_AW;
  localparam int IVT_DEPTH = 1 << IRQ_W;

  logic             advance;
  logic             c_hit0, c_hit1, c_win;
  rpm_class_e       c_cls;
  logic [IRQ_W-1:0] c_irq;

  logic             a_valid;
  rpm_class_e       a_cls;
  logic [RID_W-1:0] a_rid;
  logic             a_win;
  logic [IRQ_W-1:0] a_irq;
  logic [PE_W-1:0]  a_pe, a_ivt_pe;

  rpm_class_e       b_cls;

  // Both stages move together; the RAM read registers hold while stalled.
  assign advance  = !out_valid || out_ready;
  assign in_ready = advance;

  rpm_classify #(.IRQ_W(IRQ_W), .IDX_LSB(IDX_LSB), .WIN_BIT(WIN_BIT)) u_cls (
    .kind(in_kind), .addr(in_addr), .msi_data(in_msi_data),
    .w0_base(msi_w0_base), .w0_mask(msi_w0_mask),
    .w1_base(msi_w1_base), .w1_mask(msi_w1_mask),
    .hit0(c_hit0), .hit1(c_hit1), .cls(c_cls), .dma_win(c_win), .irq(c_irq)
  );

  rpm_sram #(.DEPTH(TBL_DEPTH), .WIDTH(PE_W)) u_rid_tbl (
    .clk(clk), .we(tbl_we), .waddr(tbl_waddr), .wdata(tbl_wdata),
    .re(advance), .raddr(in_rid[TBL_AW-1:0]), .rdata(a_pe)
  );

  rpm_sram #(.DEPTH(IVT_DEPTH), .WIDTH(PE_W)) u_ivt (
    .clk(clk), .we(ivt_we), .waddr(ivt_waddr), .wdata(ivt_wdata),
    .re(advance), .raddr(c_irq), .rdata(a_ivt_pe)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_valid <= 1'b0;
      a_cls   <= CLS_DMA;
      a_rid   <= '0;
      a_win   <= 1'b0;
      a_irq   <= '0;
    end else if (advance) begin
      a_valid <= in_valid;
      a_cls   <= c_cls;
      a_rid   <= in_rid;
      a_win   <= c_win;
      a_irq   <= c_irq;
    end
  end

  rpm_authorize #(.PE_W(PE_W), .RID_W(RID_W), .IRQ_W(IRQ_W)) u_auth (
    .clk(clk), .rst_n(rst_n), .advance(advance), .out_ready(out_ready),
    .a_valid(a_valid), .a_cls(a_cls), .a_pe(a_pe), .a_ivt_pe(a_ivt_pe),
    .a_rid(a_rid), .a_win(a_win), .a_irq(a_irq),
    .b_valid(out_valid), .b_cls(b_cls), .b_pe(out_pe), .b_rid(out_rid),
    .b_win(out_dma_win), .b_irq(out_irq), .b_fire(out_irq_fire),
    .b_reject(out_irq_reject), .err_flag(err_flag), .err_rid(err_rid)
  );

  assign out_class = b_cls;

  p_accept_loads_stage_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> a_valid);

  p_stage_reaches_output_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && advance) |=> out_valid);

  p_msi_only_from_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && c_cls == CLS_MSI) |-> (in_kind == KIND_WR && (c_hit0 || c_hit1)));
endmodule

// File: tb/sim_rid_partition_mapper.sv
module sim_rid_partition_mapper;
  typedef struct packed {
    logic [1:0]  kind;
    logic [15:0] rid;
    logic [63:0] addr;
    logic [10:0] data;
    logic [1:0]  cls;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 16'h0105, 64'h0800_0000_1000_0000, 11'h000, 2'd0},
    '{2'd1, 16'h0033, 64'h0000_0000_8000_0000, 11'h000, 2'd0},
    '{2'd1, 16'h0105, 64'h0000_0000_FFFF_0120, 11'h010, 2'd1},
    '{2'd1, 16'h0002, 64'h0003_0000_0000_7FF0, 11'h003, 2'd1},
    '{2'd1, 16'h00FF, 64'h0003_0000_0000_0010, 11'h7FF, 2'd1},
    '{2'd0, 16'h0044, 64'h0000_0000_FFFF_0040, 11'h000, 2'd0},
    '{2'd1, 16'h0007, 64'h0000_0001_0000_0000, 11'h000, 2'd0},
    '{2'd1, 16'h0008, 64'h0000_0000_FFFE_FFF0, 11'h000, 2'd0},
    '{2'd2, 16'h0A10, 64'h0000_0000_FFFF_0000, 11'h000, 2'd2},
    '{2'd1, 16'h0010, 64'h0000_0000_FFFF_0000, 11'h005, 2'd1},
    '{2'd1, 16'hAB05, 64'h0800_0000_0000_0000, 11'h000, 2'd0},
    '{2'd3, 16'h0020, 64'h0003_0000_0000_0000, 11'h000, 2'd0},
    '{2'd1, 16'h0006, 64'h0003_0000_000F_FFF0, 11'h000, 2'd1},
    '{2'd1, 16'h0007, 64'h0003_0000_0010_0000, 11'h000, 2'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic tbl_we = 1'b0, ivt_we = 1'b0;
  logic [7:0] tbl_waddr = '0, tbl_wdata = '0, ivt_wdata = '0;
  logic [10:0] ivt_waddr = '0;
  logic [63:0] w0_base = 64'h0000_0000_FFFF_0000, w0_mask = 64'h0000_0000_0000_FFFF;
  logic [63:0] w1_base = 64'h0003_0000_0000_0000, w1_mask = 64'h0000_0000_000F_FFFF;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic [1:0] in_kind = '0;
  logic [15:0] in_rid = '0;
  logic [63:0] in_addr = '0;
  logic [10:0] in_msi_data = '0;
  logic in_ready, out_valid, out_dma_win, out_irq_fire, out_irq_reject, err_flag;
  logic [1:0] out_class;
  logic [7:0] out_pe;
  logic [15:0] out_rid, err_rid;
  logic [10:0] out_irq;

  logic [7:0] rid_sh [256];
  logic [7:0] ivt_sh [2048];
  int n_chk = 0, n_bad = 0, n_fire = 0, n_rej = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rid_partition_mapper u0 (
    .clk(clk), .rst_n(rst_n),
    .tbl_we(tbl_we), .tbl_waddr(tbl_waddr), .tbl_wdata(tbl_wdata),
    .ivt_we(ivt_we), .ivt_waddr(ivt_waddr), .ivt_wdata(ivt_wdata),
    .msi_w0_base(w0_base), .msi_w0_mask(w0_mask),
    .msi_w1_base(w1_base), .msi_w1_mask(w1_mask),
    .in_valid(in_valid), .in_ready(in_ready), .in_kind(in_kind), .in_rid(in_rid),
    .in_addr(in_addr), .in_msi_data(in_msi_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_class(out_class),
    .out_pe(out_pe), .out_rid(out_rid), .out_dma_win(out_dma_win), .out_irq(out_irq),
    .out_irq_fire(out_irq_fire), .out_irq_reject(out_irq_reject),
    .err_flag(err_flag), .err_rid(err_rid)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr_tbl(input int idx, input logic [7:0] pe);
    @(negedge clk);
    tbl_we = 1'b1; tbl_waddr = idx[7:0]; tbl_wdata = pe;
    @(negedge clk);
    tbl_we = 1'b0;
    rid_sh[idx] = pe;
  endtask

  task automatic wr_ivt(input int idx, input logic [7:0] pe);
    @(negedge clk);
    ivt_we = 1'b1; ivt_waddr = idx[10:0]; ivt_wdata = pe;
    @(negedge clk);
    ivt_we = 1'b0;
    ivt_sh[idx] = pe;
  endtask

  // Expected result per the requirements, from bench shadow tables.
  task automatic check_result(input vec_t v);
    logic [7:0] pe;
    logic [10:0] irq;
    logic fire;
    pe = rid_sh[v.rid[7:0]];
    irq = (v.cls == 2'd1) ? (v.data + v.addr[14:4]) : 11'd0;
    fire = (v.cls == 2'd1) && (ivt_sh[irq] == pe);
    chk("R4", "class", {62'd0, out_class}, {62'd0, v.cls});
    chk("R2", "partition", {56'd0, out_pe}, {56'd0, pe});
    chk("R2", "rid", {48'd0, out_rid}, {48'd0, v.rid});
    chk("R3", "dma window", {63'd0, out_dma_win}, {63'd0, (v.cls == 2'd0) ? v.addr[59] : 1'b0});
    chk("R5", "irq index", {53'd0, out_irq}, {53'd0, irq});
    chk("R6", "fire", {63'd0, out_irq_fire}, {63'd0, fire});
    chk("R6", "reject", {63'd0, out_irq_reject}, {63'd0, (v.cls == 2'd1) && !fire});
    if (out_irq_fire) n_fire++;
    if (out_irq_reject) n_rej++;
  endtask

  task automatic run_pass(input bit stall_mode, input bit chk_lat);
    int acc [NV];
    int sent = 0, got = 0, cyc = 0;
    logic hold = 1'b0;
    logic [1:0] s_cls;
    logic [7:0] s_pe;
    logic [10:0] s_irq;
    logic s_fire;
    while (got < NV && cyc < 400) begin
      @(negedge clk);
      cyc++;
      if (hold) begin
        chk("R9", "valid held", {63'd0, out_valid}, 64'd1);
        chk("R9", "class held", {62'd0, out_class}, {62'd0, s_cls});
        chk("R9", "pe held", {56'd0, out_pe}, {56'd0, s_pe});
        chk("R9", "irq held", {53'd0, out_irq}, {53'd0, s_irq});
        chk("R9", "fire held", {63'd0, out_irq_fire}, {63'd0, s_fire});
      end
      out_ready = stall_mode ? ((cyc % 3) != 0) : 1'b1;
      #1;
      hold = out_valid && !out_ready;
      if (hold) begin
        s_cls = out_class; s_pe = out_pe; s_irq = out_irq; s_fire = out_irq_fire;
        chk("R9", "in_ready low while stalled", {63'd0, in_ready}, 64'd0);
      end
      if (out_valid && out_ready) begin
        check_result(VEC[got]);
        if (chk_lat) chk("R8", "latency", 64'(cyc - acc[got]), 64'd2);
        got++;
      end
      if (sent < NV) begin
        in_valid = 1'b1; in_kind = VEC[sent].kind; in_rid = VEC[sent].rid;
        in_addr = VEC[sent].addr; in_msi_data = VEC[sent].data;
      end else begin
        in_valid = 1'b0;
      end
      #1;
      if (in_valid && in_ready) begin
        acc[sent] = cyc;
        sent++;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b1;
    chk("R8", "results returned", 64'(got), 64'(NV));
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1", "out_valid after reset", {63'd0, out_valid}, 64'd0);
    chk("R1", "err_flag after reset", {63'd0, err_flag}, 64'd0);
    chk("R1", "err_rid after reset", {48'd0, err_rid}, 64'd0);
    chk("R1", "in_ready after reset", {63'd0, in_ready}, 64'd1);

    for (int i = 0; i < 256; i++) wr_tbl(i, 8'((i * 7 + 3) & 8'hFF));
    for (int j = 0; j < 2048; j++) wr_ivt(j, 8'((j * 5 + 1) & 8'hFF));
    wr_ivt(34, 8'h26);
    wr_ivt(0, 8'hFC);
    chk("R10", "no flag before any rejection", {63'd0, err_flag}, 64'd0);

    // Streaming pass: exact latency and one result per cycle (R8).
    run_pass(1'b0, 1'b1);
    chk("R6", "authorized count", 64'(n_fire), 64'd2);
    chk("R6", "rejected count", 64'(n_rej), 64'd3);
    chk("R10", "flag after rejections", {63'd0, err_flag}, 64'd1);
    chk("R10", "first rejected rid kept", {48'd0, err_rid}, 64'h0002);

    // Back-pressure pass (R9).
    run_pass(1'b1, 1'b0);
    chk("R10", "rid still first after more rejections", {48'd0, err_rid}, 64'h0002);

    do_reset();
    chk("R1", "out_valid after second reset", {63'd0, out_valid}, 64'd0);
    chk("R1", "err_flag after second reset", {63'd0, err_flag}, 64'd0);

    // Table rewrite is seen by later transactions (R2).
    wr_tbl(5, 8'h99);
    run_pass(1'b0, 1'b1);
    chk("R10", "first rejection after reset recorded", {48'd0, err_rid}, 64'h0105);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R8 watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule